// File: doc/BRIEF.md
# CAN Transmit Fault Confinement Unit

This block holds a CAN node's transmit and receive error counters and turns the transmit count into the node's fault confinement state. It consumes one-cycle event strobes from the protocol engine: a transmit error, a bit error raised while the node sends an active error flag or an overload flag, and receive-side increment and decrement requests. It also takes a sampled-bit strobe that carries the bus level. It drives the two counts, a two-bit state code, one flag per degraded state, and a transmit enable that the frame transmitter must respect.

While the node is bus-off, the block watches the sampled bits for idle bus. A run is a stretch of consecutive recessive bits of a fixed length. A dominant bit throws away a partial run. When the required number of runs has been seen, both counters return to zero, and on the next cycle the node is active again.

Every pin is a plain control or status signal. No data moves as a stream, so there is no valid/ready handshake and no back-pressure. Each strobe that is high at a rising clock edge counts as one event.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, `tec_o` is 0, `rec_o` is 0, `state_o` is 2'b00, all three flags are low, and `tx_en_o` is high.
- R2: Each of `tx_err_i` and `flag_bit_err_i` adds 8 to the transmit count in the edge that samples it. If both are high in the same cycle, the count rises by 16. The 9-bit count saturates at 511 and never wraps.
- R3: `rx_inc_i` adds 1 to the receive count, saturating at 255. `rx_dec_i` subtracts 1 and stops at 0. If both are high in the same cycle, the count is unchanged.
- R4: `state_o` encodes the transmit count as follows: 2'b00 below 96, 2'b01 from 96 to 127, 2'b10 from 128 to 255, and 2'b11 above 255. The state follows a counter change one clock later.
- R5: `warn_o`, `passive_o` and `busoff_o` are high exactly in states 01, 10 and 11. At most one of them is high at a time. `tx_en_o` is low only in state 11.
- R6: While `state_o` is 11, the four error strobes change neither counter.
- R7: A run counts only in state 11. A run is 11 sampled bits in a row with `bit_level_i` high (recessive), each marked by `bit_valid_i`. A low (dominant) sampled bit restarts the current run. Sampled bits have no effect in the other states.
- R8: In the edge that completes the 128th run, both counters become 0. `state_o` returns to 00 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_i | input | 1 | Transmit error event strobe |
| flag_bit_err_i | input | 1 | Bit error while sending an active error flag or an overload flag |
| rx_inc_i | input | 1 | Receive count increment strobe |
| rx_dec_i | input | 1 | Receive count decrement strobe |
| bit_valid_i | input | 1 | A sampled bus bit is present this cycle |
| bit_level_i | input | 1 | Level of the sampled bit, 1 = recessive |
| tec_o | output | 9 | Transmit error count |
| rec_o | output | 8 | Receive error count |
| state_o | output | 2 | Confinement state code |
| warn_o | output | 1 | Transmitter warning state |
| passive_o | output | 1 | Error-passive state |
| busoff_o | output | 1 | Bus-off state |
| tx_en_o | output | 1 | Transmission permitted |

## Verification
A wrong step size or a missed strobe shows on `tec_o` or `rec_o` one clock after the event. The state pins show it one clock after that, and only if a threshold has been crossed. A corrupted idle-run counter stays hidden for the whole bus-off period. It shows only at the end of recovery, as an exit about 1400 bit strobes too early or too late, so the bench counts recessive runs exactly and checks the pins both just before and at the final run. The bench also interrupts a run with a dominant bit, and it feeds idle bits outside bus-off to confirm that they are ignored.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_WARN    = 2'b01,
    FC_PASSIVE = 2'b10,
    FC_BUSOFF  = 2'b11
  } fc_state_e;

  // Map a transmit count onto the confinement state.
  function automatic fc_state_e fc_classify(input int unsigned cnt,
                                            input int unsigned warn_lim,
                                            input int unsigned pass_lim,
                                            input int unsigned off_lim);
    if (cnt >= off_lim)       return FC_BUSOFF;
    else if (cnt >= pass_lim) return FC_PASSIVE;
    else if (cnt >= warn_lim) return FC_WARN;
    else                      return FC_ACTIVE;
  endfunction

endpackage

// File: rtl/can_fc_tec.sv
module can_fc_tec #(
  parameter int TEC_W = 9,
  parameter int STEP  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             clear_i,
  input  logic             tx_err_i,
  input  logic             flag_err_i,
  output logic [TEC_W-1:0] tec_o
);
  localparam logic [TEC_W:0] STEPV = (TEC_W+1)'(STEP);
  localparam logic [TEC_W:0] MAXV  = {1'b0, {TEC_W{1'b1}}};

  logic [TEC_W-1:0] tec_q, tec_nxt;
  logic [TEC_W:0]   add, sum;

  always_comb begin
    add = '0;
    if (tx_err_i)   add = add + STEPV;
    if (flag_err_i) add = add + STEPV;
    sum = {1'b0, tec_q} + add;
    tec_nxt = (sum > MAXV) ? MAXV[TEC_W-1:0] : sum[TEC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tec_q <= '0;
    else if (clear_i) tec_q <= '0;
    else if (!hold_i) tec_q <= tec_nxt;
  end

  assign tec_o = tec_q;
endmodule

// File: rtl/can_fc_rec.sv
module can_fc_rec #(
  parameter int REC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [REC_W-1:0] rec_o
);
  localparam logic [REC_W-1:0] TOP = {REC_W{1'b1}};

  logic [REC_W-1:0] rec_q, rec_nxt;

  always_comb begin
    rec_nxt = rec_q;
    unique case ({inc_i, dec_i})
      2'b10:   if (rec_q != TOP) rec_nxt = rec_q + 1'b1;
      2'b01:   if (rec_q != '0)  rec_nxt = rec_q - 1'b1;
      default: rec_nxt = rec_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rec_q <= '0;
    else if (clear_i) rec_q <= '0;
    else if (!hold_i) rec_q <= rec_nxt;
  end

  assign rec_o = rec_q;
endmodule

// File: rtl/can_fc_recov.sv
module can_fc_recov #(
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic bit_valid_i,
  input  logic bit_level_i,
  output logic done_o
);
  localparam int RUN_W = (RUN_LEN   > 1) ? $clog2(RUN_LEN)   : 1;
  localparam int OCC_W = (RUN_COUNT > 1) ? $clog2(RUN_COUNT) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [OCC_W-1:0] OCC_LAST = OCC_W'(RUN_COUNT - 1);

  logic [RUN_W-1:0] run_q;
  logic [OCC_W-1:0] occ_q;
  logic             run_end;

  assign run_end = enable_i && bit_valid_i && bit_level_i && (run_q == RUN_LAST);
  assign done_o  = run_end && (occ_q == OCC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      occ_q <= '0;
    end else if (!enable_i || done_o) begin
      run_q <= '0;
      occ_q <= '0;
    end else if (bit_valid_i) begin
      if (!bit_level_i) begin
        run_q <= '0;
      end else if (run_end) begin
        run_q <= '0;
        occ_q <= occ_q + 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_fc_state.sv
module can_fc_state
  import can_fc_pkg::*;
#(
  parameter int TEC_W    = 9,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int OFF_LIM  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TEC_W-1:0] tec_i,
  output fc_state_e        state_o
);
  fc_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FC_ACTIVE;
    else        state_q <= fc_classify({{(32-TEC_W){1'b0}}, tec_i},
                                       WARN_LIM, PASS_LIM, OFF_LIM);
  end

  assign state_o = state_q;
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int TEC_W     = 9,
  parameter int REC_W     = 8,
  parameter int STEP      = 8,
  parameter int WARN_LIM  = 96,
  parameter int PASS_LIM  = 128,
  parameter int OFF_LIM   = 256,
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err_i,
  input  logic             flag_bit_err_i,
  input  logic             rx_inc_i,
  input  logic             rx_dec_i,
  input  logic             bit_valid_i,
  input  logic             bit_level_i,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o,
  output logic [1:0]       state_o,
  output logic             warn_o,
  output logic             passive_o,
  output logic             busoff_o,
  output logic             tx_en_o
);
  fc_state_e st;
  logic      off, recov_done;

  assign off = (st == FC_BUSOFF);

  can_fc_tec #(.TEC_W(TEC_W), .STEP(STEP)) u_tec (
    .clk(clk), .rst_n(rst_n), .hold_i(off), .clear_i(recov_done),
    .tx_err_i(tx_err_i), .flag_err_i(flag_bit_err_i), .tec_o(tec_o)
  );

  can_fc_rec #(.REC_W(REC_W)) u_rec (
    .clk(clk), .rst_n(rst_n), .hold_i(off), .clear_i(recov_done),
    .inc_i(rx_inc_i), .dec_i(rx_dec_i), .rec_o(rec_o)
  );

  can_fc_recov #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_recov (
    .clk(clk), .rst_n(rst_n), .enable_i(off),
    .bit_valid_i(bit_valid_i), .bit_level_i(bit_level_i), .done_o(recov_done)
  );

  can_fc_state #(.TEC_W(TEC_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM),
                 .OFF_LIM(OFF_LIM)) u_state (
    .clk(clk), .rst_n(rst_n), .tec_i(tec_o), .state_o(st)
  );

  assign state_o   = st;
  assign warn_o    = (st == FC_WARN);
  assign passive_o = (st == FC_PASSIVE);
  assign busoff_o  = off;
  assign tx_en_o   = !off;
endmodule

// File: rtl/can_fc_chk.sv
module can_fc_chk
  import can_fc_pkg::*;
#(
  parameter int TEC_W    = 9,
  parameter int REC_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int OFF_LIM  = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_err_i,
  input logic             flag_bit_err_i,
  input logic             rx_inc_i,
  input logic             rx_dec_i,
  input logic             bit_valid_i,
  input logic             bit_level_i,
  input logic [TEC_W-1:0] tec_o,
  input logic [REC_W-1:0] rec_o,
  input logic [1:0]       state_o,
  input logic             warn_o,
  input logic             passive_o,
  input logic             busoff_o,
  input logic             tx_en_o
);
  assert_tec_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busoff_o && !tx_err_i && !flag_bit_err_i) |=> $stable(tec_o));

  assert_tec_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busoff_o && tx_err_i) |=> (tec_o >= $past(tec_o)));

  assert_rec_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busoff_o && rec_o == '0 && rx_dec_i && !rx_inc_i) |=> (rec_o == '0));

  assert_state_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (state_o == 2'(fc_classify({{(32-TEC_W){1'b0}}, $past(tec_o)},
                                         WARN_LIM, PASS_LIM, OFF_LIM))));

  assert_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({warn_o, passive_o, busoff_o}) && (busoff_o != tx_en_o));

  assert_busoff_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff_o && !bit_valid_i) |=> ($stable(tec_o) && $stable(rec_o)));

  assert_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff_o && tec_o == '0) |=> (!busoff_o && rec_o == '0));
endmodule

bind can_fault_conf can_fc_chk #(
  .TEC_W(TEC_W), .REC_W(REC_W), .WARN_LIM(WARN_LIM),
  .PASS_LIM(PASS_LIM), .OFF_LIM(OFF_LIM)
) u_chk (.*);

// File: tb/tb_can_fault_conf.sv
module tb_can_fault_conf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_err_i = 0, flag_bit_err_i = 0, rx_inc_i = 0, rx_dec_i = 0;
  logic bit_valid_i = 0, bit_level_i = 0;
  logic [8:0] tec_o;
  logic [7:0] rec_o;
  logic [1:0] state_o;
  logic warn_o, passive_o, busoff_o, tx_en_o;

  int checks = 0;
  int errors = 0;
  int exp_tec = 0;
  int exp_rec = 0;

  typedef struct {
    int    tec;
    int    rec;
    int    st;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  can_fault_conf dut (.*);

  function automatic int cls(input int t);
    if (t > 255)      return 3;
    else if (t > 127) return 2;
    else if (t > 95)  return 1;
    else              return 0;
  endfunction

  task automatic push(input string tag);
    exp_t e;
    e.tec = exp_tec; e.rec = exp_rec; e.st = cls(exp_tec); e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compare the oldest expectation against the pins.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      int got_flags, exp_flags;
      e = sb.pop_front();
      got_flags = {warn_o, passive_o, busoff_o, tx_en_o};
      exp_flags = {e.st == 1, e.st == 2, e.st == 3, e.st != 3};
      checks++;
      if (int'(tec_o) != e.tec || int'(rec_o) != e.rec ||
          int'(state_o) != e.st || got_flags != exp_flags) begin
        errors++;
        $display("FAIL %s: tec=%0d rec=%0d st=%0d flags=%b, expected tec=%0d rec=%0d st=%0d flags=%b",
                 e.tag, tec_o, rec_o, state_o, got_flags[3:0],
                 e.tec, e.rec, e.st, exp_flags[3:0]);
      end
    end
  end

  task automatic settle_push(input string tag);
    @(negedge clk); #1;
    push(tag);
    wait (sb.size() == 0);
  endtask

  // One cycle of strobes, then the model update.
  task automatic pulse(input logic tx, input logic fl, input logic inc,
                       input logic dec, input string tag);
    @(negedge clk);
    tx_err_i = tx; flag_bit_err_i = fl; rx_inc_i = inc; rx_dec_i = dec;
    @(negedge clk);
    tx_err_i = 0; flag_bit_err_i = 0; rx_inc_i = 0; rx_dec_i = 0;
    if (cls(exp_tec) != 3) begin
      exp_tec = exp_tec + 8 * (int'(tx) + int'(fl));
      if (exp_tec > 511) exp_tec = 511;
      if (inc && !dec && exp_rec < 255) exp_rec++;
      if (dec && !inc && exp_rec > 0)   exp_rec--;
    end
    settle_push(tag);
  endtask

  task automatic bits(input logic lvl, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid_i = 1; bit_level_i = lvl;
    end
    @(negedge clk);
    bit_valid_i = 0; bit_level_i = 0;
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle_push("R1 reset state");

    pulse(0, 0, 0, 1, "R3 decrement at zero");
    for (int i = 0; i < 3; i++) pulse(0, 0, 1, 0, "R3 increment");
    pulse(0, 0, 1, 1, "R3 both strobes hold");
    pulse(0, 0, 0, 1, "R3 decrement");

    @(negedge clk); rx_inc_i = 1;
    repeat (300) @(negedge clk);
    rx_inc_i = 0;
    exp_rec = 255;
    settle_push("R3 saturate at 255");
    pulse(0, 0, 0, 1, "R3 decrement from top");

    bits(1, 11 * 128);
    settle_push("R7 idle bits ignored when active");

    for (int i = 0; i < 11; i++) pulse(1, 0, 0, 0, "R2 R4 tx error while active");
    pulse(0, 1, 0, 0, "R2 R4 R5 flag error 88->96 warning");
    pulse(1, 1, 0, 0, "R2 both strobes add 16");
    pulse(1, 0, 0, 0, "R2 R4 tx error 112->120");

    // 120 -> 128: the count moves first, the state one cycle later.
    @(negedge clk); tx_err_i = 1;
    @(negedge clk); tx_err_i = 0;
    exp_tec = 128;
    checks++;
    if (tec_o != 9'd128 || state_o != 2'b01) begin
      errors++;
      $display("FAIL R4 lag: tec=%0d st=%0d, expected tec=128 st=1", tec_o, state_o);
    end
    settle_push("R4 R5 passive at 128");

    while (exp_tec < 248) pulse(1, 0, 0, 0, "R2 R4 tx error while passive");
    pulse(1, 0, 0, 0, "R4 R5 248->256 bus-off");

    pulse(1, 0, 0, 0, "R6 tx error ignored in bus-off");
    pulse(0, 1, 1, 0, "R6 flag and rx strobes ignored in bus-off");
    pulse(0, 0, 0, 1, "R6 rx decrement ignored in bus-off");

    bits(1, 10);
    bits(0, 1);
    bits(1, 11 * 127);
    settle_push("R7 dominant restarts run, still bus-off");
    bits(1, 10);
    settle_push("R7 one bit short, still bus-off");
    bits(1, 1);
    exp_tec = 0; exp_rec = 0;
    settle_push("R8 recovery clears counters");
    pulse(1, 0, 0, 0, "R2 counting resumes after recovery");

    wait (sb.size() == 0);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule